// File: doc/BRIEF.md
# Gated Frame Buffer Drain Master

This block is the host-side SPI master that pulls one received frame out of a radio transceiver's buffer. On a start request it lowers chip select and shifts out a read command byte. It then waits a fixed settling interval so that the transceiver's shared status pin becomes meaningful as a "buffer empty" flag. After that it clocks in data bytes one at a time, starting each byte only while that flag is low.

The first data byte carries the frame length in its low seven bits. That many payload bytes follow under the same flag gating. Three trailing status bytes are then read without looking at the flag, because the transceiver appends them and does not hold them in its buffer. Each byte appears on a registered output stream with a valid strobe, and a last strobe marks the final status byte. If the flag stays high for longer than two octet periods while the master waits for a buffered byte, the read is abandoned. Chip select is released, an abort strobe pulses, and a sticky error flag rises. That flag stays high until the next start request.

Top module: `frame_drain_master`

## Requirements
- R1: After reset, spi_csn_o is high, spi_sclk_o is low, and byte_valid_o, byte_last_o, done_o, abort_o and err_o are all low.
- R2: A start request in the idle state drives spi_csn_o low and shifts out the command byte CMD_RD, most significant bit first, in SPI mode 0 (clock idles low, data sampled on the rising edge).
- R3: After the command byte's last clock edge, no further clock edge occurs for at least VALID_DLY_CYC clock cycles.
- R4: A byte taken from the buffer (the length byte or a payload byte) starts only while empty_i is low. While empty_i is high between such bytes, spi_sclk_o does not toggle, and the transfer resumes once empty_i falls.
- R5: The frame length is bits [6:0] of the first data byte, and bit 7 is ignored. Exactly 1 + length + 3 bytes are delivered on byte_o, in the order received, each with a one-cycle byte_valid_o.
- R6: The three trailing status bytes are transferred without regard to empty_i.
- R7: byte_last_o is high only together with the final status byte. One cycle later spi_csn_o returns high and done_o pulses for one cycle.
- R8: While the master waits for a buffered byte, empty_i held high for more than 2*OCTET_CYC consecutive cycles aborts the read. The stall count restarts from zero each time a wait ends.
- R9: On abort, spi_csn_o goes high, abort_o pulses and err_o is set. err_o then holds until the next start request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to read one frame (accepted when idle) |
| empty_i | input | 1 | Buffer empty flag from the transceiver, high means no data ready |
| spi_miso_i | input | 1 | SPI data from the transceiver |
| spi_sclk_o | output | 1 | SPI clock, idles low |
| spi_mosi_o | output | 1 | SPI data to the transceiver |
| spi_csn_o | output | 1 | SPI chip select, active low |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o holds a new byte this cycle |
| byte_last_o | output | 1 | Marks the final status byte of the frame |
| done_o | output | 1 | One-cycle pulse when the read finishes normally |
| abort_o | output | 1 | One-cycle pulse when the read is abandoned on a stall |
| err_o | output | 1 | Sticky stall error, cleared by the next start |

## Verification
Several properties are checked every cycle. The clock stays low whenever the shifter is idle, and the shifter stays idle during the settling interval. No gated byte begins while the flag is high. The last strobe never appears without a valid strobe. Done and abort follow from the last byte and from a completed stall. The error flag never drops without a start. Other behaviour only the bench scenarios can show: the exact byte order and count for several lengths, that the length's top bit is masked, that the clock really pauses during a stall and resumes afterwards, that the status bytes ignore the flag, and that the abort comes after the full two-octet window and not earlier.

// File: rtl/frame_drain_pkg.sv
package frame_drain_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_CMD,
    FR_DLY,
    FR_WAIT,
    FR_XFER,
    FR_END
  } fr_state_t;

  localparam int STATUS_BYTES = 3;
  localparam int LEN_BITS     = 7;
endpackage

// File: rtl/fd_spi_byte.sv
module fd_spi_byte #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          hi_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;
  logic [7:0]    rx_q;
  logic          act_q;
  logic          sclk_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      hi_q   <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go_i) begin
          act_q <= 1'b1;
          tx_q  <= tx_i;
          div_q <= '0;
          hi_q  <= 1'b0;
          bit_q <= '0;
        end
      end else if (div_q == DW'(HALF_DIV - 1)) begin
        div_q <= '0;
        if (!hi_q) begin
          sclk_q <= 1'b1;
          hi_q   <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          hi_q   <= 1'b0;
          tx_q   <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R2: mode 0 clock rests low whenever no byte is in flight
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !sclk_q);
endmodule

// File: rtl/fd_stall_timer.sv
module fd_stall_timer #(
  parameter int LIMIT = 6400
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT));

  // R8: expiry needs a stall that was already running on the previous cycle
  a_r8_expiry_after_stall: assert property (@(posedge clk) disable iff (rst)
    expired_o |-> $past(run_i));
endmodule

// File: rtl/frame_drain_master.sv
module frame_drain_master
  import frame_drain_pkg::*;
#(
  parameter int         HALF_DIV      = 4,
  parameter int         VALID_DLY_CYC = 75,
  parameter int         OCTET_CYC     = 3200,
  parameter logic [7:0] CMD_RD        = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       empty_i,
  input  logic       spi_miso_i,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  output logic       spi_csn_o,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_last_o,
  output logic       done_o,
  output logic       abort_o,
  output logic       err_o
);
  localparam int STALL_LIMIT = 2 * OCTET_CYC;
  localparam int DLW         = $clog2(VALID_DLY_CYC + 1);
  localparam int SW          = $clog2(STATUS_BYTES + 1);

  fr_state_t           state_q;
  logic [DLW-1:0]      dly_q;
  logic                gated_q;
  logic                first_q;
  logic [LEN_BITS-1:0] left_q;
  logic [SW-1:0]       stat_q;
  logic                csn_q, valid_q, last_q, done_q, abort_q, err_q;
  logic [7:0]          byte_q;

  logic       eng_go, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       stall_run, stall_exp;

  always_comb begin
    eng_go = 1'b0;
    eng_tx = 8'h00;
    if (state_q == FR_IDLE && start_i) begin
      eng_go = 1'b1;
      eng_tx = CMD_RD;
    end else if (state_q == FR_WAIT && (!gated_q || !empty_i)) begin
      eng_go = 1'b1;
    end
  end

  assign stall_run = (state_q == FR_WAIT) && gated_q && empty_i;

  fd_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go_i   (eng_go),
    .tx_i   (eng_tx),
    .miso_i (spi_miso_i),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  fd_stall_timer #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk       (clk),
    .rst       (rst),
    .run_i     (stall_run),
    .expired_o (stall_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      dly_q   <= '0;
      gated_q <= 1'b0;
      first_q <= 1'b0;
      left_q  <= '0;
      stat_q  <= '0;
      csn_q   <= 1'b1;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      case (state_q)
        FR_IDLE: begin
          if (start_i) begin
            csn_q   <= 1'b0;
            err_q   <= 1'b0;
            state_q <= FR_CMD;
          end
        end
        FR_CMD: begin
          if (eng_done) begin
            dly_q   <= '0;
            gated_q <= 1'b1;
            first_q <= 1'b1;
            stat_q  <= SW'(STATUS_BYTES);
            state_q <= FR_DLY;
          end
        end
        FR_DLY: begin
          if (dly_q == DLW'(VALID_DLY_CYC - 1)) state_q <= FR_WAIT;
          else                                  dly_q   <= dly_q + DLW'(1);
        end
        FR_WAIT: begin
          if (stall_exp) begin
            csn_q   <= 1'b1;
            abort_q <= 1'b1;
            err_q   <= 1'b1;
            state_q <= FR_IDLE;
          end else if (eng_go) begin
            state_q <= FR_XFER;
          end
        end
        FR_XFER: begin
          if (eng_done) begin
            byte_q  <= eng_rx;
            valid_q <= 1'b1;
            state_q <= FR_WAIT;
            if (gated_q) begin
              if (first_q) begin
                first_q <= 1'b0;
                if (eng_rx[LEN_BITS-1:0] == '0) gated_q <= 1'b0;
                else                            left_q  <= eng_rx[LEN_BITS-1:0];
              end else begin
                if (left_q == LEN_BITS'(1)) gated_q <= 1'b0;
                left_q <= left_q - LEN_BITS'(1);
              end
            end else if (stat_q == SW'(1)) begin
              last_q  <= 1'b1;
              state_q <= FR_END;
            end else begin
              stat_q <= stat_q - SW'(1);
            end
          end
        end
        FR_END: begin
          csn_q   <= 1'b1;
          done_q  <= 1'b1;
          state_q <= FR_IDLE;
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  assign spi_csn_o    = csn_q;
  assign byte_o       = byte_q;
  assign byte_valid_o = valid_q;
  assign byte_last_o  = last_q;
  assign done_o       = done_q;
  assign abort_o      = abort_q;
  assign err_o        = err_q;

  // R3: shifter stays idle for the whole settling interval
  a_r3_quiet_in_delay: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_DLY) |-> !eng_busy);
  // R4: a buffered byte is launched only with the flag low
  a_r4_gated_start_low: assert property (@(posedge clk) disable iff (rst)
    (eng_go && gated_q && state_q == FR_WAIT) |-> !empty_i);
  // R7: last only accompanies a valid byte
  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    byte_last_o |-> byte_valid_o);
  // R7: done follows the last byte by one cycle
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(byte_last_o));
  // R9: abort releases the bus and raises the error
  a_r9_abort_releases: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (spi_csn_o && err_o));
  // R9: error is sticky until a start
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o);
endmodule

// File: tb/frame_drain_master_tb_top.sv
module frame_drain_master_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 2;
  localparam int         VDLY       = 8;
  localparam int         OCT        = 20;
  localparam logic [7:0] CMD        = 8'h20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       empty_i = 1'b0;
  logic       miso = 1'b0;
  logic       sclk, mosi, csn;
  logic [7:0] byte_o;
  logic       valid, last, done, abort, err;

  int tests_run = 0;
  int tests_fail = 0;

  logic [7:0] mem [0:31];
  logic [7:0] got [0:31];
  int rx_cnt, last_cnt, last_idx, done_cnt, abort_cnt;
  int bitcnt, sclk_rises;
  logic [7:0] cmd_cap;
  time t_cmd_end, t_first;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_drain_master #(
    .HALF_DIV(HALF), .VALID_DLY_CYC(VDLY), .OCTET_CYC(OCT), .CMD_RD(CMD)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .empty_i(empty_i),
    .spi_miso_i(miso), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
    .spi_csn_o(csn), .byte_o(byte_o), .byte_valid_o(valid),
    .byte_last_o(last), .done_o(done), .abort_o(abort), .err_o(err)
  );

  // transceiver model: command capture, buffer bytes out on falling edges
  always @(negedge csn) begin
    bitcnt = 0;
    miso = 1'b0;
  end
  always @(posedge sclk) begin
    sclk_rises++;
    if (bitcnt == 8) t_first = $time;
    if (bitcnt < 8) cmd_cap = {cmd_cap[6:0], mosi};
    bitcnt++;
  end
  always @(negedge sclk) begin
    if (bitcnt == 8) t_cmd_end = $time;
    if (bitcnt >= 8 && bitcnt < 8 * 33) miso = mem[bitcnt/8 - 1][7 - (bitcnt % 8)];
  end

  // output monitor, sampled just after each edge
  always @(posedge clk) begin
    #1;
    if (valid) begin
      if (rx_cnt < 32) got[rx_cnt] = byte_o;
      if (last) begin
        last_cnt++;
        last_idx = rx_cnt;
      end
      rx_cnt++;
    end
    if (done) done_cnt++;
    if (abort) abort_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_cnt = 0; last_cnt = 0; last_idx = -1; done_cnt = 0; abort_cnt = 0;
    cmd_cap = 8'h00;
  endtask

  task automatic load(input int len, input logic [7:0] phr);
    mem[0] = phr;
    for (int i = 1; i <= len; i++) mem[i] = 8'(8'h30 + i * 7);
    mem[len + 1] = 8'hA5;
    mem[len + 2] = 8'h5A;
    mem[len + 3] = 8'hC3;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt > 0 || abort_cnt > 0) break;
    end
  endtask

  task automatic wait_count(input int n);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rx_cnt >= n) break;
    end
  endtask

  task automatic check_frame(input int len, input string req);
    int n;
    n = len + 4;
    check(rx_cnt == n, {req, " byte count"}, rx_cnt, n);
    for (int i = 0; i < n && i < 32; i++)
      check(got[i] == mem[i], {req, " byte value"}, got[i], mem[i]);
    check(last_cnt == 1 && last_idx == n - 1, "R7 last position", last_idx, n - 1);
    check(done_cnt == 1, "R7 done pulse", done_cnt, 1);
    check(abort_cnt == 0, "R7 no abort", abort_cnt, 0);
    check(csn == 1'b1, "R7 csn released", csn, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(csn == 1'b1 && sclk == 1'b0, "R1 bus idle", {csn, sclk}, 2);
    check({valid, last, done, abort, err} == 5'b0, "R1 status low",
          {valid, last, done, abort, err}, 0);
  endtask

  task automatic t_plain();
    clear_mon(); load(4, 8'h04); empty_i = 1'b0;
    pulse_start();
    check(csn == 1'b0, "R2 csn low after start", csn, 0);
    wait_end();
    check(cmd_cap == CMD, "R2 command byte", cmd_cap, CMD);
    check((t_first - t_cmd_end) / CLK_PERIOD >= VDLY, "R3 settle gap",
          int'((t_first - t_cmd_end) / CLK_PERIOD), VDLY);
    check_frame(4, "R5");
  endtask

  task automatic t_stall();
    int snap;
    clear_mon(); load(3, 8'h03); empty_i = 1'b0;
    pulse_start();
    for (int k = 1; k <= 2; k++) begin
      wait_count(k);
      empty_i = 1'b1;
      snap = sclk_rises;
      repeat (2 * OCT - 8) @(negedge clk);
      check(sclk_rises == snap, "R4 clock paused while flag high", sclk_rises, snap);
      check(abort_cnt == 0, "R8 no abort below window", abort_cnt, 0);
      empty_i = 1'b0;
    end
    wait_end();
    check_frame(3, "R4");
  endtask

  task automatic t_status_ignore();
    clear_mon(); load(2, 8'h02); empty_i = 1'b0;
    pulse_start();
    wait_count(3);
    empty_i = 1'b1;
    wait_end();
    empty_i = 1'b0;
    check_frame(2, "R6");
  endtask

  task automatic t_mask();
    clear_mon(); load(5, 8'h85); empty_i = 1'b0;
    pulse_start();
    wait_end();
    check_frame(5, "R5 top bit masked");
  endtask

  task automatic t_zero();
    clear_mon(); load(0, 8'h00); empty_i = 1'b0;
    pulse_start();
    wait_end();
    check_frame(0, "R5 zero length");
  endtask

  task automatic t_abort();
    int waited, snap;
    clear_mon(); load(4, 8'h04); empty_i = 1'b0;
    pulse_start();
    wait_count(1);
    empty_i = 1'b1;
    snap = sclk_rises;
    waited = 0;
    for (int i = 0; i < 4 * OCT + 20; i++) begin
      if (abort_cnt > 0) break;
      @(negedge clk);
      waited++;
    end
    check(abort_cnt == 1, "R8 abort raised", abort_cnt, 1);
    check(waited >= 2 * OCT && waited <= 2 * OCT + 4, "R8 abort timing", waited, 2 * OCT + 1);
    check(sclk_rises == snap, "R4 no clock during stall", sclk_rises, snap);
    check(done_cnt == 0, "R9 no done on abort", done_cnt, 0);
    repeat (20) @(negedge clk);
    check(err == 1'b1 && csn == 1'b1, "R9 error sticky, bus released", {err, csn}, 3);
    empty_i = 1'b0;
    clear_mon(); load(1, 8'h01);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(err == 1'b0, "R9 start clears error", err, 0);
    wait_end();
    check_frame(1, "R9 read after abort");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    sclk_rises = 0; bitcnt = 0; t_cmd_end = 0; t_first = 0;
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    repeat (5) @(negedge clk);
    t_stall();
    repeat (5) @(negedge clk);
    t_status_ignore();
    repeat (5) @(negedge clk);
    t_mask();
    repeat (5) @(negedge clk);
    t_zero();
    repeat (5) @(negedge clk);
    t_abort();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end
endmodule